// File: doc/BRIEF.md
# Decode stage skid-buffer controller

This block sits between instruction fetch and register rename in a single-thread pipeline. Each cycle it receives a group of up to `W` instruction slots from fetch, each slot carrying a valid bit, a squashed bit and a sequence-number tag. It forwards up to `W` live instructions per cycle to rename. The instructions are packed into the low output slots and keep their arrival order. Slots marked squashed are discarded and never use an output slot.

When any downstream stage (rename, execute or commit) holds its stall flag, the stage stops issuing. It parks the live instructions that keep arriving in a skid buffer, so none are lost while fetch reacts to the block pulse. Once the stalls clear, the stage drains the skid buffer oldest first, with later arrivals queued behind. It returns to normal flow only when the buffer is empty. A squash from commit discards everything held. An ongoing reorder-buffer squash keeps the stage quiet. Fetch is told of changes through one-cycle block and unblock pulses rather than a level.

Top module: `dec_skid_stage`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `dec_state` reads 0 (Idle), all stall flags are clear, `rn_vld` is zero and neither fetch pulse is raised. The state encoding is 0 Idle, 1 Running, 2 Blocked, 3 Unblocking and 4 Squashing.
- R2: A cycle with `cm_squash` high takes priority over every other input. Next cycle the state is Squashing. The skid buffer and that cycle's fetch group are discarded and nothing is sent to rename. `fe_unblock` pulses only if the state was Blocked or Unblocking.
- R3: The skid buffer holds `LAT*FW+W` entries (8 at default parameters) and keeps entries in order when completely full. An assertion reports any push beyond capacity, and such entries are dropped.
- R4: Without a commit squash, `rob_squash` high makes the next state Squashing. The fetch group is dropped, nothing goes to rename and the skid contents are kept.
- R5: Each of the three sticky stall flags (rename, execute, commit) is set by its block pulse and cleared by its unblock pulse, and the clear wins if both arrive together. A flag acts from the following cycle, and the stage is stalled while any flag is set.
- R6: A stalled cycle appends that cycle's live fetch instructions to the skid buffer in order and sends nothing to rename, and the next state is Blocked. `fe_block` pulses only if the state was not already Blocked.
- R7: In Blocked or Unblocking with no squash and no stall, the stage sends up to `W` of the oldest skid entries to rename and appends the live fetch instructions behind the remaining entries.
- R8: Unblocking ends on the cycle in which the skid buffer becomes empty after that cycle's removals and additions. That cycle gives one `fe_unblock` pulse and a next state of Running; otherwise the next state is Unblocking.
- R9: From Squashing, with no squash and no stall, the state becomes Running and that cycle's live fetch instructions are forwarded.
- R10: Slots with the squashed bit set are dropped. Live instructions fill `rn_vld` from bit 0 upward with no gaps, in slot order.
- R11: In Idle or Running, the live fetch instructions appear at the rename outputs one cycle later. Idle stays Idle and Running stays Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fe_vld | input | W | Fetch slot valid bits |
| fe_sq | input | W | Fetch slot squashed marks |
| fe_seq | input | W*SW | Fetch slot sequence tags, slot 0 in the low bits |
| rn_blk | input | 1 | Rename block pulse |
| rn_unb | input | 1 | Rename unblock pulse |
| ex_blk | input | 1 | Execute block pulse |
| ex_unb | input | 1 | Execute unblock pulse |
| cm_blk | input | 1 | Commit block pulse |
| cm_unb | input | 1 | Commit unblock pulse |
| cm_squash | input | 1 | Squash request from commit |
| rob_squash | input | 1 | Reorder buffer still squashing |
| rn_vld | output | W | Valid bits of the group sent to rename |
| rn_seq | output | W*SW | Tags of the group sent to rename |
| fe_block | output | 1 | One-cycle block pulse to fetch |
| fe_unblock | output | 1 | One-cycle unblock pulse to fetch |
| dec_state | output | 3 | Current control state |

## Verification
The assertions check several properties on every cycle. The skid buffer never accepts more than it holds and never gives out more than it has. The output group is always packed. Both fetch pulses are never raised together, and each pulse matches the state it leads into. The stall flags follow their set and clear pulses, a commit squash always leads to a quiet Squashing cycle, and Blocked sends nothing to rename. Some behaviours can only be shown by the bench's scenarios, which a reference queue model checks cycle by cycle. These are the exact ordering of drained and newly queued tags, the cycle on which Unblocking ends, the single block pulse over a long stall, and the discarding of held entries on a squash.

// File: rtl/dec_skid_pkg.sv
// Shared state type of the decode skid controller.
// Assumes the encoding is visible on the dec_state port.
package dec_skid_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_BLK   = 3'd2,
        ST_UNBLK = 3'd3,
        ST_SQ    = 3'd4
    } dstate_e;
endpackage

// File: rtl/dec_stall_flags.sv
// Sticky per-stage stall flags. Set by a block pulse, cleared by an unblock
// pulse (clear wins); registered, so a pulse acts from the next cycle.
module dec_stall_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] blk,
    input  logic [N-1:0] unb,
    output logic         stalled
);
    logic [N-1:0] flg;

    // Per-stage flag registers.
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) flg[g] <= 1'b0;
            else        flg[g] <= (flg[g] | blk[g]) & ~unb[g];
        end

        p_unblock_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            unb[g] |=> !flg[g]);
        p_block_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (blk[g] && !unb[g]) |=> flg[g]);
    end

    assign stalled = |flg;
endmodule

// File: rtl/dec_compact.sv
// Packs the live (valid and not squashed) slots of a fetch group into the
// low positions, keeping slot order. Purely combinational.
module dec_compact #(
    parameter int W  = 4,
    parameter int SW = 8,
    localparam int NW = $clog2(W + 1)
) (
    input  logic [W-1:0]         in_vld,
    input  logic [W-1:0]         in_sq,
    input  logic [W-1:0][SW-1:0] in_seq,
    output logic [NW-1:0]        out_n,
    output logic [W-1:0][SW-1:0] out_seq
);
    // Walk the slots and place each live one at the next free position.
    always_comb begin
        int n;
        n = 0;
        out_seq = '0;
        for (int i = 0; i < W; i++) begin
            if (in_vld[i] && !in_sq[i]) begin
                out_seq[n] = in_seq[i];
                n = n + 1;
            end
        end
        out_n = NW'(n);
    end
endmodule

// File: rtl/dec_skid_buf.sv
// Circular skid buffer with multi-entry push and pop in one cycle.
// Pop is applied before push; flush empties it. Assumes pop_n <= cnt.
module dec_skid_buf #(
    parameter int W     = 4,
    parameter int DEPTH = 8,
    parameter int SW    = 8,
    localparam int NW = $clog2(W + 1),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [NW-1:0]        push_n,
    input  logic [W-1:0][SW-1:0] push_seq,
    input  logic [NW-1:0]        pop_n,
    output logic [CW-1:0]        cnt,
    output logic [W-1:0][SW-1:0] peek_seq
);
    logic [SW-1:0] mem [DEPTH];
    logic [PW-1:0] rd;
    logic [CW-1:0] cnt_nx;

    // Oldest W entries as seen from the read pointer.
    always_comb begin
        for (int i = 0; i < W; i++)
            peek_seq[i] = mem[PW'((int'(rd) + i) % DEPTH)];
    end

    // Next occupancy, capped at capacity (excess pushes dropped).
    always_comb begin
        int t;
        t = int'(cnt) - int'(pop_n) + int'(push_n);
        if (t > DEPTH) t = DEPTH;
        cnt_nx = CW'(t);
    end

    // Pointer and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd  <= '0;
            cnt <= '0;
        end else begin
            rd  <= PW'((int'(rd) + int'(pop_n)) % DEPTH);
            cnt <= cnt_nx;
        end
    end

    // Storage writes behind the current tail.
    always_ff @(posedge clk) begin
        if (rst_n && !flush) begin
            for (int i = 0; i < W; i++) begin
                if (i < int'(push_n) && (int'(cnt) - int'(pop_n) + i) < DEPTH)
                    mem[PW'((int'(rd) + int'(cnt) + i) % DEPTH)] <= push_seq[i];
            end
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (int'(cnt) - int'(pop_n) + int'(push_n)) <= DEPTH);
    p_pop_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> pop_n <= NW'(W) && int'(pop_n) <= int'(cnt));
endmodule

// File: rtl/dec_skid_stage.sv
// Single-thread decode stage with skid buffer and block/unblock/squash
// control. Inputs are prioritised: commit squash, reorder-buffer squash,
// stall, then state progress. Outputs and fetch pulses are registered.
module dec_skid_stage
    import dec_skid_pkg::*;
#(
    parameter int W   = 4,
    parameter int FW  = 4,
    parameter int LAT = 1,
    parameter int SW  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         fe_vld,
    input  logic [W-1:0]         fe_sq,
    input  logic [W-1:0][SW-1:0] fe_seq,
    input  logic                 rn_blk,
    input  logic                 rn_unb,
    input  logic                 ex_blk,
    input  logic                 ex_unb,
    input  logic                 cm_blk,
    input  logic                 cm_unb,
    input  logic                 cm_squash,
    input  logic                 rob_squash,
    output logic [W-1:0]         rn_vld,
    output logic [W-1:0][SW-1:0] rn_seq,
    output logic                 fe_block,
    output logic                 fe_unblock,
    output logic [2:0]           dec_state
);
    localparam int DEPTH = LAT * FW + W;
    localparam int NW    = $clog2(W + 1);
    localparam int CW    = $clog2(DEPTH + 1);

    dstate_e st, nxt;
    logic stalled, flush, o_skid, blk_p, unb_p;
    logic [NW-1:0] lv_n, pop_n, push_n, o_n;
    logic [CW-1:0] sk_cnt;
    logic [W-1:0][SW-1:0] lv_seq, sk_seq;

    dec_stall_flags #(.N(3)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .blk({cm_blk, ex_blk, rn_blk}),
        .unb({cm_unb, ex_unb, rn_unb}),
        .stalled(stalled)
    );

    dec_compact #(.W(W), .SW(SW)) u_pack (
        .in_vld(fe_vld), .in_sq(fe_sq), .in_seq(fe_seq),
        .out_n(lv_n), .out_seq(lv_seq)
    );

    dec_skid_buf #(.W(W), .DEPTH(DEPTH), .SW(SW)) u_skid (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_n(push_n), .push_seq(lv_seq), .pop_n(pop_n),
        .cnt(sk_cnt), .peek_seq(sk_seq)
    );

    // Prioritised next-state, buffer control and pulse decision.
    always_comb begin
        nxt = st; flush = 1'b0; o_skid = 1'b0; blk_p = 1'b0; unb_p = 1'b0;
        pop_n = '0; push_n = '0; o_n = '0;
        if (cm_squash) begin
            nxt   = ST_SQ;
            flush = 1'b1;
            unb_p = (st == ST_BLK) || (st == ST_UNBLK);
        end else if (rob_squash) begin
            nxt = ST_SQ;
        end else if (stalled) begin
            nxt    = ST_BLK;
            push_n = lv_n;
            blk_p  = (st != ST_BLK);
        end else if (st == ST_BLK || st == ST_UNBLK) begin
            pop_n  = (int'(sk_cnt) >= W) ? NW'(W) : NW'(sk_cnt);
            o_n    = pop_n;
            o_skid = 1'b1;
            push_n = lv_n;
            if (int'(sk_cnt) - int'(pop_n) + int'(lv_n) == 0) begin
                unb_p = 1'b1;
                nxt   = ST_RUN;
            end else begin
                nxt = ST_UNBLK;
            end
        end else begin
            o_n = lv_n;
            if (st == ST_SQ) nxt = ST_RUN;
        end
    end

    // State, rename outputs and fetch pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            rn_vld     <= '0;
            rn_seq     <= '0;
            fe_block   <= 1'b0;
            fe_unblock <= 1'b0;
        end else begin
            st         <= nxt;
            fe_block   <= blk_p;
            fe_unblock <= unb_p;
            for (int i = 0; i < W; i++) begin
                rn_vld[i] <= (i < int'(o_n));
                rn_seq[i] <= (i < int'(o_n)) ? (o_skid ? sk_seq[i] : lv_seq[i]) : '0;
            end
        end
    end

    assign dec_state = st;

    p_pulses_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fe_block && fe_unblock));
    p_block_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fe_block |-> dec_state == 3'd2);
    p_unblock_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fe_unblock |-> (dec_state == 3'd1 || dec_state == 3'd4));
    p_blocked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_state == 3'd2 |-> rn_vld == '0);
    p_squash_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cm_squash |=> (dec_state == 3'd4 && rn_vld == '0));
    p_rob_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cm_squash && rob_squash) |=> dec_state == 3'd4);
    p_packed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_vld & (rn_vld + W'(1))) == '0);
endmodule

// File: tb/sim_dec_skid_stage.sv
`timescale 1ns/1ps
module sim_dec_skid_stage;
    localparam int W = 4, FW = 4, LAT = 1, SW = 8;
    localparam int DEPTH = LAT * FW + W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [W-1:0] fe_vld = '0, fe_sq = '0;
    logic [W-1:0][SW-1:0] fe_seq = '0;
    logic rn_blk = 0, rn_unb = 0, ex_blk = 0, ex_unb = 0, cm_blk = 0, cm_unb = 0;
    logic cm_squash = 0, rob_squash = 0;
    logic [W-1:0] rn_vld;
    logic [W-1:0][SW-1:0] rn_seq;
    logic fe_block, fe_unblock;
    logic [2:0] dec_state;

    always #2 clk = ~clk;

    dec_skid_stage #(.W(W), .FW(FW), .LAT(LAT), .SW(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .fe_vld(fe_vld), .fe_sq(fe_sq), .fe_seq(fe_seq),
        .rn_blk(rn_blk), .rn_unb(rn_unb), .ex_blk(ex_blk), .ex_unb(ex_unb),
        .cm_blk(cm_blk), .cm_unb(cm_unb), .cm_squash(cm_squash),
        .rob_squash(rob_squash), .rn_vld(rn_vld), .rn_seq(rn_seq),
        .fe_block(fe_block), .fe_unblock(fe_unblock), .dec_state(dec_state)
    );

    int checks = 0, errors = 0;
    int mst = 0;
    bit fl [3];
    int q[$];
    logic [W-1:0] e_vld;
    logic [W-1:0][SW-1:0] e_seq;
    logic e_blk, e_unb;
    string tag;
    int seqc = 1;

    // Behavioural reference: one call per rising edge, inputs stable.
    task automatic model();
        int lv[$];
        bit stl;
        int k;
        stl = fl[0] | fl[1] | fl[2];
        for (int i = 0; i < W; i++) if (fe_vld[i] && !fe_sq[i]) lv.push_back(int'(fe_seq[i]));
        e_vld = '0; e_seq = '0; e_blk = 0; e_unb = 0;
        if (cm_squash) begin
            tag = "R2"; e_unb = (mst == 2 || mst == 3); q.delete(); mst = 4;
        end else if (rob_squash) begin
            tag = "R4"; mst = 4;
        end else if (stl) begin
            tag = "R5 R6"; e_blk = (mst != 2);
            foreach (lv[j]) if (q.size() < DEPTH) q.push_back(lv[j]);
            if (q.size() == DEPTH) tag = "R3 R6";
            mst = 2;
        end else if (mst == 2 || mst == 3) begin
            tag = "R7"; k = 0;
            while (q.size() > 0 && k < W) begin
                e_vld[k] = 1'b1; e_seq[k] = SW'(q.pop_front()); k++;
            end
            foreach (lv[j]) q.push_back(lv[j]);
            if (q.size() == 0) begin tag = "R8"; e_unb = 1; mst = 1; end
            else mst = 3;
        end else begin
            tag = (mst == 4) ? "R9" : "R10 R11";
            foreach (lv[j]) begin e_vld[j] = 1'b1; e_seq[j] = SW'(lv[j]); end
            if (mst == 4) mst = 1;
        end
        fl[0] = (fl[0] | rn_blk) & ~rn_unb;
        fl[1] = (fl[1] | ex_blk) & ~ex_unb;
        fl[2] = (fl[2] | cm_blk) & ~cm_unb;
    endtask

    task automatic compare();
        checks++;
        if (rn_vld !== e_vld || rn_seq !== e_seq || fe_block !== e_blk ||
            fe_unblock !== e_unb || dec_state !== 3'(mst)) begin
            errors++;
            $display("FAIL %s: got vld=%b seq=%h blk=%b unb=%b st=%0d exp vld=%b seq=%h blk=%b unb=%b st=%0d",
                     tag, rn_vld, rn_seq, fe_block, fe_unblock, dec_state,
                     e_vld, e_seq, e_blk, e_unb, mst);
        end
    endtask

    // One clock: model at the edge, compare at the falling edge, clear inputs.
    task automatic tick();
        @(posedge clk); model(); @(negedge clk); compare();
        fe_vld = '0; fe_sq = '0; fe_seq = '0;
        rn_blk = 0; rn_unb = 0; ex_blk = 0; ex_unb = 0; cm_blk = 0; cm_unb = 0;
        cm_squash = 0; rob_squash = 0;
    endtask

    task automatic grp(input logic [W-1:0] v, input logic [W-1:0] s);
        fe_vld = v; fe_sq = s;
        for (int i = 0; i < W; i++) begin fe_seq[i] = SW'(seqc); seqc++; end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1 reset state
        if (dec_state !== 3'd0 || rn_vld !== '0 || fe_block !== 0 || fe_unblock !== 0) begin
            errors++;
            $display("FAIL R1: got st=%0d vld=%b blk=%b unb=%b exp 0 0 0 0",
                     dec_state, rn_vld, fe_block, fe_unblock);
        end
        rst_n = 1'b1;
        tag = "R1"; e_vld = '0; e_seq = '0; e_blk = 0; e_unb = 0;
        compare();
        // R11 R10: Idle forwarding with squashed and invalid slots
        grp(4'b1111, 4'b0000); tick();
        grp(4'b1111, 4'b0101); tick();
        grp(4'b1011, 4'b0010); tick();
        // R5 R6 R3 R7 R8: rename stall, fill skid exactly, drain
        rn_blk = 1; grp(4'b1111, 4'b0000); tick();
        grp(4'b1111, 4'b0000); tick();
        grp(4'b1111, 4'b0000); tick();
        rn_unb = 1; tick();
        grp(4'b0011, 4'b0000); tick();
        tick(); tick(); tick();
        // R5: two flags, set and clear together (clear wins)
        ex_blk = 1; cm_blk = 1; grp(4'b0001, 4'b0000); tick();
        ex_unb = 1; tick();
        rn_blk = 1; rn_unb = 1; tick();
        cm_unb = 1; tick();
        grp(4'b0111, 4'b0000); tick();
        tick(); tick();
        // R2: squash while Unblocking, then R9 recovery
        rn_blk = 1; tick();
        grp(4'b1111, 4'b0000); tick();
        grp(4'b1111, 4'b0000); tick();
        rn_unb = 1; tick();
        tick();
        cm_squash = 1; grp(4'b1111, 4'b0000); tick();
        grp(4'b1101, 4'b0000); tick();
        // R4: reorder-buffer squash keeps skid, then stall from Squashing
        rob_squash = 1; grp(4'b1111, 4'b0000); tick();
        rob_squash = 1; cm_blk = 1; tick();
        grp(4'b0011, 4'b0000); tick();
        cm_unb = 1; tick();
        tick(); tick();
        // R2: squash while Running and while Blocked
        cm_squash = 1; grp(4'b1111, 4'b0000); tick();
        tick();
        ex_blk = 1; tick();
        grp(4'b0001, 4'b0000); tick();
        cm_squash = 1; ex_unb = 1; tick();
        tick(); tick();
        // Mixed random traffic, kept within skid capacity
        for (int c = 0; c < 400; c++) begin
            int r;
            r = int'($urandom % 100);
            if (q.size() + W <= DEPTH) grp(4'($urandom), 4'($urandom));
            if (r < 8) rn_blk = 1; else if (r < 16) rn_unb = 1;
            else if (r < 20) ex_blk = 1; else if (r < 26) ex_unb = 1;
            else if (r < 29) cm_blk = 1; else if (r < 35) cm_unb = 1;
            else if (r < 38) cm_squash = 1; else if (r < 41) rob_squash = 1;
            tick();
        end
        rn_unb = 1; ex_unb = 1; cm_unb = 1; tick();
        repeat (4) tick();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got no finish exp finish");
        finish_run();
    end
endmodule